// File: doc/BRIEF.md
# Doorbell Message Mailbox with Acknowledge

This block passes messages one way between two processors. Each processor has its own 32-bit register port on a shared register map. The sending side (A) writes up to 32 message words into a shared bank. It then sets a ring event, which raises side B's interrupt. The receiving side (B) reads the words back and sets an acknowledge event, which raises side A's interrupt.

By convention, the low 7 bits of word 0 carry the payload length in bytes, so the receiver reads ceil(length/4) words. The hardware does not interpret this field.

Both events are held in one common status register, and either side clears them with a write-one-to-clear register. Each side has its own enable mask over that status. An interrupt output is a level signal and stays high until the status bit behind it is cleared or masked.

Top module: `msg_doorbell_mbox`

## Requirements
- R1: After reset, every message word, the status register and both enable registers read 0, both interrupt outputs are low, and both read-data outputs are 0.
- R2: A write from either side to byte offset 4*i (i = 0..31) stores that word. A read from either side of the same offset returns it on the read-data output in the cycle after the read request is sampled.
- R3: When both sides write the same message word in the same cycle, the value from side A is stored.
- R4: Writing the event register at offset 0x80 behaves as follows. Bit 0 set to 1 sets ring status (status bit 0). Bit 1 set to 1 sets acknowledge status (status bit 1). A 0 in either bit leaves that status bit unchanged, and all other data bits are ignored.
- R5: Writing the clear register at offset 0xC4 clears every status bit whose data bit is 1 and leaves the others unchanged.
- R6: When a set of a status bit and a clear of the same bit happen in the same cycle, from the same side or from different sides, the bit ends up set.
- R7: a_irq is the OR of (status AND enable A) and b_irq is the OR of (status AND enable B). Each interrupt stays high as long as the status bit and enable bit behind it stay set.
- R8: Enable A lives at offset 0xBC, enable B at 0xC0 and status at 0xC8. Only bits 1:0 of these registers are stored, and their upper bits read 0. When both sides write the same enable register in the same cycle, side A's value is stored.
- R9: A read of any other offset returns 0, including the event register, the clear register, and 0x84 to 0xB8. A write to an offset outside the map changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_we | input | 1 | Side A write strobe |
| a_re | input | 1 | Side A read strobe |
| a_addr | input | 8 | Side A byte address (bits 1:0 ignored) |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, registered |
| a_irq | output | 1 | Side A interrupt, level |
| b_we | input | 1 | Side B write strobe |
| b_re | input | 1 | Side B read strobe |
| b_addr | input | 8 | Side B byte address (bits 1:0 ignored) |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, registered |
| b_irq | output | 1 | Side B interrupt, level |

## Verification
A write lands on the clock edge that samples it. Status, enables and both interrupt outputs therefore show the new value right after that edge. Read data is registered, so it appears one edge after the read request is sampled.

The bench drives each access on a falling edge and holds it across one rising edge. It then samples results on the following falling edge, which is exactly where each of these values has just become valid. The interrupt mapping is swept over all 64 combinations of status and the two enable masks.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int unsigned OFS_EVENT = 32'h80;
   localparam int unsigned OFS_EN_A  = 32'hBC;
   localparam int unsigned OFS_EN_B  = 32'hC0;
   localparam int unsigned OFS_CLEAR = 32'hC4;
   localparam int unsigned OFS_STAT  = 32'hC8;
   localparam int unsigned NUM_EVT   = 2;
   localparam int unsigned NUM_SIDE  = 2;

   typedef enum logic [2:0] {
      RG_MSG, RG_EVENT, RG_EN_A, RG_EN_B, RG_CLEAR, RG_STAT, RG_NONE
   } region_e;

   function automatic region_e mbox_decode(input logic [31:0] byte_addr,
                                           input int unsigned words);
      logic [31:0] w;
      w = {byte_addr[31:2], 2'b00};
      if (w < words * 4) return RG_MSG;
      case (w)
         OFS_EVENT: return RG_EVENT;
         OFS_EN_A:  return RG_EN_A;
         OFS_EN_B:  return RG_EN_B;
         OFS_CLEAR: return RG_CLEAR;
         OFS_STAT:  return RG_STAT;
         default:   return RG_NONE;
      endcase
   endfunction
endpackage

// File: rtl/mbox_msg_bank.sv
module mbox_msg_bank #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 32,
   localparam int unsigned IDX_W = $clog2(WORDS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wa_en,
   input  logic [IDX_W-1:0]              wa_idx,
   input  logic [DATA_W-1:0]             wa_data,
   input  logic                          wb_en,
   input  logic [IDX_W-1:0]              wb_idx,
   input  logic [DATA_W-1:0]             wb_data,
   output logic [WORDS-1:0][DATA_W-1:0]  bank
);
   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic hit_a, hit_b;
      assign hit_a = wa_en && (wa_idx == IDX_W'(i));
      assign hit_b = wb_en && (wb_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     bank[i] <= '0;
         else if (hit_a) bank[i] <= wa_data;
         else if (hit_b) bank[i] <= wb_data;
      end
   end
endmodule

// File: rtl/mbox_event_ctrl.sv
module mbox_event_ctrl #(
   parameter int unsigned NUM_EVT  = 2,
   parameter int unsigned NUM_SIDE = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_SIDE-1:0]              evt_we,
   input  logic [NUM_SIDE-1:0]              clr_we,
   input  logic [NUM_SIDE-1:0]              ena_we,
   input  logic [NUM_SIDE-1:0]              enb_we,
   input  logic [NUM_SIDE-1:0][NUM_EVT-1:0] wbits,
   output logic [NUM_EVT-1:0]               status,
   output logic [NUM_EVT-1:0]               en_a,
   output logic [NUM_EVT-1:0]               en_b,
   output logic                             irq_a,
   output logic                             irq_b
);
   logic [NUM_EVT-1:0] set_m, clr_m;

   always_comb begin
      set_m = '0;
      clr_m = '0;
      for (int s = 0; s < NUM_SIDE; s++) begin
         if (evt_we[s]) set_m = set_m | wbits[s];
         if (clr_we[s]) clr_m = clr_m | wbits[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr_m) | set_m;
   end

   // lowest-numbered side has priority on a shared enable write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_a <= '0;
         en_b <= '0;
      end else begin
         for (int s = NUM_SIDE - 1; s >= 0; s--) begin
            if (ena_we[s]) en_a <= wbits[s];
            if (enb_we[s]) en_b <= wbits[s];
         end
      end
   end

   assign irq_a = |(status & en_a);
   assign irq_b = |(status & en_b);
endmodule

// File: rtl/mbox_rd_port.sv
module mbox_rd_port
   import mbox_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WORDS     = 32,
   parameter int unsigned NUM_EVT   = 2,
   parameter bit          REG_RDATA = 1'b1,
   localparam int unsigned IDX_W    = $clog2(WORDS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          re,
   input  region_e                       region,
   input  logic [IDX_W-1:0]              idx,
   input  logic [WORDS-1:0][DATA_W-1:0]  bank,
   input  logic [NUM_EVT-1:0]            status,
   input  logic [NUM_EVT-1:0]            en_a,
   input  logic [NUM_EVT-1:0]            en_b,
   output logic [DATA_W-1:0]             rdata
);
   logic [DATA_W-1:0] mux;

   always_comb begin
      case (region)
         RG_MSG:  mux = bank[idx];
         RG_EN_A: mux = DATA_W'(en_a);
         RG_EN_B: mux = DATA_W'(en_b);
         RG_STAT: mux = DATA_W'(status);
         default: mux = '0;
      endcase
   end

   if (REG_RDATA) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  rdata <= '0;
         else if (re) rdata <= mux;
      end
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n};
      assign rdata = re ? mux : '0;
   end
endmodule

// File: rtl/msg_doorbell_mbox.sv
module msg_doorbell_mbox
   import mbox_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned MSG_WORDS = 32,
   parameter bit          REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_we,
   input  logic              a_re,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_irq,
   input  logic              b_we,
   input  logic              b_re,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_irq
);
   localparam int unsigned IDX_W = $clog2(MSG_WORDS);

   if (MSG_WORDS < 2 || MSG_WORDS > 32) begin : g_bad_words
      $error("MSG_WORDS must lie in 2..32");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 8..32");
   end
   if (DATA_W < NUM_EVT || DATA_W > 32) begin : g_bad_data
      $error("DATA_W must lie in NUM_EVT..32");
   end

   logic [NUM_SIDE-1:0]              we_s, re_s;
   logic [NUM_SIDE-1:0][ADDR_W-1:0]  addr_s;
   logic [NUM_SIDE-1:0][DATA_W-1:0]  wdata_s, rdata_s;
   logic [NUM_SIDE-1:0][IDX_W-1:0]   idx_s;
   logic [NUM_SIDE-1:0][NUM_EVT-1:0] wbits_s;
   logic [NUM_SIDE-1:0]              msg_we, evt_we, clr_we, ena_we, enb_we;
   region_e                          region_s [NUM_SIDE];

   logic [MSG_WORDS-1:0][DATA_W-1:0] bank;
   logic [NUM_EVT-1:0]               st_q, ena_q, enb_q;

   assign we_s    = {b_we, a_we};
   assign re_s    = {b_re, a_re};
   assign addr_s  = {b_addr, a_addr};
   assign wdata_s = {b_wdata, a_wdata};

   for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
      assign region_s[s] = mbox_decode(32'(addr_s[s]), MSG_WORDS);
      assign idx_s[s]    = addr_s[s][IDX_W+1:2];
      assign wbits_s[s]  = wdata_s[s][NUM_EVT-1:0];
      assign msg_we[s]   = we_s[s] && (region_s[s] == RG_MSG);
      assign evt_we[s]   = we_s[s] && (region_s[s] == RG_EVENT);
      assign clr_we[s]   = we_s[s] && (region_s[s] == RG_CLEAR);
      assign ena_we[s]   = we_s[s] && (region_s[s] == RG_EN_A);
      assign enb_we[s]   = we_s[s] && (region_s[s] == RG_EN_B);

      mbox_rd_port #(
         .DATA_W(DATA_W), .WORDS(MSG_WORDS), .NUM_EVT(NUM_EVT), .REG_RDATA(REG_RDATA)
      ) u_rd (
         .clk(clk), .rst_n(rst_n), .re(re_s[s]), .region(region_s[s]),
         .idx(idx_s[s]), .bank(bank), .status(st_q), .en_a(ena_q), .en_b(enb_q),
         .rdata(rdata_s[s])
      );
   end

   mbox_msg_bank #(.DATA_W(DATA_W), .WORDS(MSG_WORDS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wa_en(msg_we[0]), .wa_idx(idx_s[0]), .wa_data(wdata_s[0]),
      .wb_en(msg_we[1]), .wb_idx(idx_s[1]), .wb_data(wdata_s[1]),
      .bank(bank)
   );

   mbox_event_ctrl #(.NUM_EVT(NUM_EVT), .NUM_SIDE(NUM_SIDE)) u_evt (
      .clk(clk), .rst_n(rst_n),
      .evt_we(evt_we), .clr_we(clr_we), .ena_we(ena_we), .enb_we(enb_we),
      .wbits(wbits_s), .status(st_q), .en_a(ena_q), .en_b(enb_q),
      .irq_a(a_irq), .irq_b(b_irq)
   );

   assign a_rdata = rdata_s[0];
   assign b_rdata = rdata_s[1];
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
   import mbox_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned MSG_WORDS = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              a_we,
   input logic              a_re,
   input logic [ADDR_W-1:0] a_addr,
   input logic [DATA_W-1:0] a_wdata,
   input logic [DATA_W-1:0] a_rdata,
   input logic              a_irq,
   input logic              b_we,
   input logic              b_addr_dummy,
   input logic [ADDR_W-1:0] b_addr,
   input logic [DATA_W-1:0] b_wdata,
   input logic              b_irq,
   input logic [NUM_EVT-1:0] st_q
);
   region_e ra, rb;
   assign ra = mbox_decode(32'(a_addr), MSG_WORDS);
   assign rb = mbox_decode(32'(b_addr), MSG_WORDS);

   logic ev_a, ev_b, cl_a, cl_b, ea_w, eb_w;
   assign ev_a = a_we && ra == RG_EVENT;
   assign ev_b = b_we && rb == RG_EVENT;
   assign cl_a = a_we && ra == RG_CLEAR;
   assign cl_b = b_we && rb == RG_CLEAR;
   assign ea_w = (a_we && ra == RG_EN_A) || (b_we && rb == RG_EN_A);
   assign eb_w = (a_we && ra == RG_EN_B) || (b_we && rb == RG_EN_B);

   logic ring_set, ack_set, ring_clr;
   assign ring_set = (ev_a && a_wdata[0]) || (ev_b && b_wdata[0]);
   assign ack_set  = (ev_a && a_wdata[1]) || (ev_b && b_wdata[1]);
   assign ring_clr = (cl_a && a_wdata[0]) || (cl_b && b_wdata[0]);

   logic unused_ok;
   assign unused_ok = &{1'b0, b_addr_dummy};

   AST_RING_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ring_set |=> st_q[0]); // R6
   AST_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ack_set |=> st_q[1]); // R4
   AST_RING_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_clr && !ring_set) |=> !st_q[0]); // R5
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_a && !ev_b && !cl_a && !cl_b) |=> $stable(st_q)); // R4
   AST_AIRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (a_irq && !cl_a && !cl_b && !ea_w) |=> a_irq); // R7
   AST_BIRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (b_irq && !cl_a && !cl_b && !eb_w) |=> b_irq); // R7
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (a_re && (ra == RG_NONE || ra == RG_EVENT || ra == RG_CLEAR)) |=> a_rdata == '0); // R9
endmodule

bind msg_doorbell_mbox mbox_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MSG_WORDS(MSG_WORDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .a_we(a_we), .a_re(a_re), .a_addr(a_addr),
   .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq), .b_we(b_we),
   .b_addr_dummy(b_re), .b_addr(b_addr), .b_wdata(b_wdata), .b_irq(b_irq),
   .st_q(st_q)
);

// File: tb/msg_doorbell_mbox_tb.sv
module msg_doorbell_mbox_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_we = 0, a_re = 0, b_we = 0, b_re = 0;
   logic [7:0]  a_addr = 0, b_addr = 0;
   logic [31:0] a_wdata = 0, b_wdata = 0;
   logic [31:0] a_rdata, b_rdata;
   logic        a_irq, b_irq;
   int          checks = 0, errors = 0;
   logic [31:0] rv;

   always #10 clk = ~clk;

   msg_doorbell_mbox u_dut (
      .clk(clk), .rst_n(rst_n),
      .a_we(a_we), .a_re(a_re), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(a_rdata), .a_irq(a_irq),
      .b_we(b_we), .b_re(b_re), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_rdata(b_rdata), .b_irq(b_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input bit side, input logic [7:0] ad, input logic [31:0] d);
      @(negedge clk);
      if (!side) begin a_we = 1; a_addr = ad; a_wdata = d; end
      else       begin b_we = 1; b_addr = ad; b_wdata = d; end
      @(negedge clk);
      a_we = 0; b_we = 0;
   endtask

   task automatic wr2(input logic [7:0] aa, input logic [31:0] ad,
                      input logic [7:0] ba, input logic [31:0] bd);
      @(negedge clk);
      a_we = 1; a_addr = aa; a_wdata = ad;
      b_we = 1; b_addr = ba; b_wdata = bd;
      @(negedge clk);
      a_we = 0; b_we = 0;
   endtask

   task automatic rd(input bit side, input logic [7:0] ad, output logic [31:0] d);
      @(negedge clk);
      if (!side) begin a_re = 1; a_addr = ad; end
      else       begin b_re = 1; b_addr = ad; end
      @(negedge clk);
      a_re = 0; b_re = 0;
      d = side ? b_rdata : a_rdata;
   endtask

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 a_irq", {31'b0, a_irq}, 0);
      check("R1 b_irq", {31'b0, b_irq}, 0);
      check("R1 a_rdata", a_rdata, 0);
      rst_n = 1;
      rd(0, 8'hC8, rv); check("R1 status", rv, 0);
      rd(1, 8'hBC, rv); check("R1 en_a", rv, 0);
      rd(0, 8'hC0, rv); check("R1 en_b", rv, 0);
      rd(1, 8'h00, rv); check("R1 word0", rv, 0);
      rd(0, 8'h7C, rv); check("R1 word31", rv, 0);

      // R2 bank sweep A->B then B->A
      for (int i = 0; i < 32; i++) wr(0, 8'(4*i), 32'hA500_0000 ^ (i * 32'h0101_0101));
      for (int i = 0; i < 32; i++) begin
         rd(1, 8'(4*i), rv); check("R2 B reads A word", rv, 32'hA500_0000 ^ (i * 32'h0101_0101));
      end
      for (int i = 0; i < 32; i++) wr(1, 8'(4*i + 3), ~(i * 32'h1234_5677));
      for (int i = 0; i < 32; i++) begin
         rd(0, 8'(4*i), rv); check("R2 A reads B word", rv, ~(i * 32'h1234_5677));
      end

      // R3 collision on message word
      wr2(8'h14, 32'hAAAA_0001, 8'h14, 32'hBBBB_0002);
      rd(1, 8'h14, rv); check("R3 side A wins", rv, 32'hAAAA_0001);

      // R8 enable storage and priority
      wr(0, 8'hBC, 32'hFFFF_FFFF); rd(0, 8'hBC, rv); check("R8 en_a masked", rv, 3);
      wr(1, 8'hC0, 32'h0000_0005); rd(1, 8'hC0, rv); check("R8 en_b masked", rv, 1);
      wr2(8'hC0, 32'h2, 8'hC0, 32'h3); rd(0, 8'hC0, rv); check("R8 en_b A priority", rv, 2);
      wr(0, 8'hBC, 2); wr(1, 8'hC0, 1);

      // R4 / R7 events
      wr(0, 8'h80, 1);
      rd(0, 8'hC8, rv); check("R4 ring sets bit0", rv, 1);
      check("R7 b_irq on ring", {31'b0, b_irq}, 1);
      check("R7 a_irq off", {31'b0, a_irq}, 0);
      wr(1, 8'h80, 2);
      rd(1, 8'hC8, rv); check("R4 ack sets bit1", rv, 3);
      check("R7 a_irq on ack", {31'b0, a_irq}, 1);
      wr(0, 8'h80, 0); rd(0, 8'hC8, rv); check("R4 zero write no effect", rv, 3);
      wr(1, 8'h80, 32'hFFFF_FFFC); rd(0, 8'hC8, rv); check("R4 upper bits ignored", rv, 3);
      repeat (5) @(negedge clk);
      check("R7 a_irq level held", {31'b0, a_irq}, 1);
      check("R7 b_irq level held", {31'b0, b_irq}, 1);

      // R5 clear
      wr(1, 8'hC4, 1); rd(0, 8'hC8, rv); check("R5 clear bit0", rv, 2);
      check("R5 b_irq dropped", {31'b0, b_irq}, 0);
      check("R5 a_irq kept", {31'b0, a_irq}, 1);
      wr(0, 8'hC4, 0); rd(0, 8'hC8, rv); check("R5 zero clear no effect", rv, 2);
      wr(0, 8'hC4, 2); rd(1, 8'hC8, rv); check("R5 clear bit1", rv, 0);

      // R6 set vs clear same cycle
      wr2(8'h80, 1, 8'hC4, 1); rd(0, 8'hC8, rv); check("R6 set wins cross-side", rv, 1);
      wr2(8'hC4, 2, 8'h80, 2); rd(0, 8'hC8, rv); check("R6 set wins bit1", rv, 3);
      wr(0, 8'hC4, 3);

      // R7 exhaustive mapping sweep
      for (int s = 0; s < 4; s++)
         for (int ea = 0; ea < 4; ea++)
            for (int eb = 0; eb < 4; eb++) begin
               wr(1, 8'hC4, 3);
               wr(0, 8'h80, 32'(s));
               wr(0, 8'hBC, 32'(ea));
               wr(1, 8'hC0, 32'(eb));
               check("R7 a_irq map", {31'b0, a_irq}, {31'b0, |(2'(s) & 2'(ea))});
               check("R7 b_irq map", {31'b0, b_irq}, {31'b0, |(2'(s) & 2'(eb))});
            end

      // R9 unmapped and write-only registers
      wr(1, 8'hC4, 3);
      wr(0, 8'h84, 32'hFFFF_FFFF);
      wr(1, 8'hA0, 32'hFFFF_FFFF);
      rd(0, 8'h84, rv); check("R9 0x84 reads 0", rv, 0);
      rd(1, 8'hFC, rv); check("R9 0xFC reads 0", rv, 0);
      rd(0, 8'h80, rv); check("R9 event reads 0", rv, 0);
      rd(1, 8'hC4, rv); check("R9 clear reads 0", rv, 0);
      rd(0, 8'hC8, rv); check("R9 status untouched", rv, 0);
      rd(0, 8'hBC, rv); check("R9 en_a untouched", rv, 3);
      rd(1, 8'h00, rv); check("R9 word0 untouched", rv, ~(32'h0));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule